// File: doc/BRIEF.md
# Parallel Configuration Byte Sequencer

This block feeds byte-wide configuration data into a serial configuration path. It runs in one of two modes. In master mode it drives an address onto an external byte-wide PROM, takes the byte that the PROM returns and moves the address on after each byte. In slave mode a processor places each byte on the data bus, and the address output is not used.

Every byte the block takes is shifted out one bit per clock edge, most significant bit first. The bits go onto an internal serial stream, which a frame receiver consumes, and onto a daisy-chain output for downstream devices. The clock is the configuration clock.

Once the frame receiver reports that loading is complete, the block raises its completion flag. The PROM enable output is active low and follows that flag, so the PROM is enabled while configuration runs and disabled afterwards.

Top module: `pcfg_byte_seq`

## Requirements
- R1: After reset the address output is 0, done_o and prom_ce_n_o are low, ser_vld_o and byte_stb_o are low, and dout_o is high.
- R2: In master mode, START_ADDR appears on addr_o from the clock edge at which start_i is sampled high.
- R3: The first byte is taken from data_i at the second rising edge after the start edge, and not at the first.
- R4: Each later byte is taken exactly eight rising edges after the previous one. byte_stb_o is high for the single cycle that follows each edge at which a byte is taken.
- R5: A byte that has been taken appears on ser_bit_o with bit 7 first. The output moves down one bit per edge, so bit 0 is shown seven cycles after bit 7.
- R6: In master mode addr_o increments by exactly one at each edge at which a byte is taken, and at no other edge after start.
- R7: In slave mode addr_o stays at 0 for the whole session, and bytes are taken from data_i with the same timing as in master mode.
- R8: mode_slave_i is sampled only while the block is idle. A change on mode_slave_i during loading has no effect on slave_o or on address stepping.
- R9: When frames_done_i is high during loading, done_o and prom_ce_n_o go high at that edge and stay high until reset. No further byte is taken, and addr_o is frozen.
- R10: After completion, the byte in flight finishes shifting. ser_vld_o then falls at the edge where the next byte would have been taken.
- R11: While ser_vld_o is high, dout_o equals ser_bit_o. While ser_vld_o is low, dout_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_slave_i | input | 1 | 1 selects slave mode, 0 selects master mode; sampled only while idle |
| start_i | input | 1 | Starts a configuration session |
| frames_done_i | input | 1 | Frame receiver reports that loading is complete |
| data_i | input | 8 | Byte from the PROM or the processor |
| addr_o | output | AW | PROM byte address |
| prom_ce_n_o | output | 1 | Active-low PROM enable |
| done_o | output | 1 | Configuration complete flag |
| slave_o | output | 1 | Mode sampled at start |
| byte_stb_o | output | 1 | Pulse in the cycle after a byte is taken |
| ser_bit_o | output | 1 | Internal serial stream bit |
| ser_vld_o | output | 1 | Serial stream valid |
| dout_o | output | 1 | Daisy-chain serial output |

## Verification
The hardest case to reach is completion arriving in the middle of a byte. At that point the block must freeze the address and stop taking bytes, yet still let the remaining bits drain and then drop the valid flag on the right edge. The bench starts a master session on a PROM model whose byte values depend on the address. It lets several bytes through, then raises frames_done_i three bits into a byte. From there it counts edges to check the last bits, the point at which valid falls, and that no strobe follows. A mid-session toggle of the mode input is placed before completion, so that the ignored-mode check is read from the address steps.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       slave;
        logic       done;
        logic       stb;
    } ctl_t;
endpackage

// File: rtl/pcfg_phase.sv
module pcfg_phase #(
    parameter int BYTE_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic run_i,
    output logic wrap_o
);
    localparam int PW = $clog2(BYTE_W);
    localparam logic [PW-1:0] LAST = PW'(BYTE_W - 1);
    localparam logic [PW-1:0] ARM  = PW'(BYTE_W - 2);

    typedef struct packed {
        logic [PW-1:0] ph;
    } ph_t;

    ph_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (arm_i) begin
            r_d.ph = ARM;
        end else if (run_i) begin
            r_d.ph = (r_q.ph == LAST) ? '0 : r_q.ph + 1'b1;
        end
    end

    assign wrap_o = run_i && (r_q.ph == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pcfg_addr.sv
module pcfg_addr #(
    parameter int AW = 16,
    parameter logic [AW-1:0] START_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          inc_i,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        logic [AW-1:0] a;
    } ad_t;

    ad_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i)     r_d.a = START_ADDR;
        else if (inc_i) r_d.a = r_q.a + 1'b1;
    end

    assign addr_o = r_q.a;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pcfg_shift.sv
module pcfg_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         drain_i,
    input  logic [W-1:0] data_i,
    output logic         bit_o,
    output logic         vld_o
);
    typedef struct packed {
        logic [W-1:0] sh;
        logic         vld;
    } sh_t;

    sh_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.sh  = data_i;
            r_d.vld = 1'b1;
        end else begin
            r_d.sh = {r_q.sh[W-2:0], 1'b0};
            if (drain_i) r_d.vld = 1'b0;
        end
    end

    assign bit_o = r_q.sh[W-1];
    assign vld_o = r_q.vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pcfg_byte_seq.sv
module pcfg_byte_seq
    import pcfg_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] START_ADDR = AW'(16'h0040)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_slave_i,
    input  logic              start_i,
    input  logic              frames_done_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [AW-1:0]     addr_o,
    output logic              prom_ce_n_o,
    output logic              done_o,
    output logic              slave_o,
    output logic              byte_stb_o,
    output logic              ser_bit_o,
    output logic              ser_vld_o,
    output logic              dout_o
);
    ctl_t c_d, c_q;

    logic wrap;
    logic arm, run, latch, inc, load_addr, drain;

    always_comb begin
        c_d       = c_q;
        c_d.stb   = 1'b0;
        arm       = 1'b0;
        latch     = 1'b0;
        load_addr = 1'b0;
        drain     = 1'b0;
        run       = (c_q.st != ST_IDLE);
        case (c_q.st)
            ST_IDLE: begin
                // R8: mode follows the pin only while idle
                c_d.slave = mode_slave_i;
                if (start_i) begin
                    c_d.st    = ST_LOAD;
                    arm       = 1'b1;
                    load_addr = !mode_slave_i;
                end
            end
            ST_LOAD: begin
                if (frames_done_i) begin
                    c_d.st   = ST_FIN;
                    c_d.done = 1'b1;
                    drain    = wrap;
                end else begin
                    latch = wrap;
                end
            end
            ST_FIN: begin
                drain = wrap;
            end
            default: c_d.st = ST_IDLE;
        endcase
        c_d.stb = latch;
        inc     = latch && !c_q.slave;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, slave: 1'b0, done: 1'b0, stb: 1'b0};
        else        c_q <= c_d;
    end

    pcfg_phase #(.BYTE_W(BYTE_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .arm_i (arm),
        .run_i (run),
        .wrap_o(wrap)
    );

    pcfg_addr #(.AW(AW), .START_ADDR(START_ADDR)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load_addr),
        .inc_i (inc),
        .addr_o(addr_o)
    );

    pcfg_shift #(.W(BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (latch),
        .drain_i(drain),
        .data_i (data_i),
        .bit_o  (ser_bit_o),
        .vld_o  (ser_vld_o)
    );

    assign done_o      = c_q.done;
    assign prom_ce_n_o = c_q.done;
    assign slave_o     = c_q.slave;
    assign byte_stb_o  = c_q.stb;
    // R11
    assign dout_o      = ser_vld_o ? ser_bit_o : 1'b1;
endmodule

// File: rtl/pcfg_byte_seq_chk.sv
module pcfg_byte_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_o,
    input logic          done_o,
    input logic          slave_o,
    input logic          byte_stb_o,
    input logic          ser_vld_o,
    input logic          ser_bit_o,
    input logic          dout_o
);
    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb_o && !slave_o) |-> (addr_o == $past(addr_o) + 1'b1));

    // R7
    slave_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slave_o |-> (addr_o == '0));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(addr_o) && !byte_stb_o));

    // R4
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb_o |=> !byte_stb_o);

    // R5
    vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_vld_o) |-> byte_stb_o);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb_o |-> $stable(slave_o));

    // R11
    dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_vld_o |-> (dout_o == ser_bit_o));
endmodule

bind pcfg_byte_seq pcfg_byte_seq_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_o    (addr_o),
    .done_o    (done_o),
    .slave_o   (slave_o),
    .byte_stb_o(byte_stb_o),
    .ser_vld_o (ser_vld_o),
    .ser_bit_o (ser_bit_o),
    .dout_o    (dout_o)
);

// File: tb/sim_pcfg_byte_seq.sv
module sim_pcfg_byte_seq;
    localparam int AW = 16;
    localparam logic [AW-1:0] START = 16'h0040;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_slave_i = 1'b0;
    logic start_i = 1'b0;
    logic frames_done_i = 1'b0;
    logic use_prom = 1'b1;
    logic [7:0] data_drv = 8'h00;
    logic [7:0] data_i;
    logic [AW-1:0] addr_o;
    logic prom_ce_n_o, done_o, slave_o, byte_stb_o, ser_bit_o, ser_vld_o, dout_o;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] prom(input logic [AW-1:0] a);
        return (a[7:0] * 8'd37 + 8'd5) ^ a[15:8];
    endfunction

    assign data_i = use_prom ? prom(addr_o) : data_drv;

    pcfg_byte_seq #(.AW(AW), .START_ADDR(START)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_slave_i(mode_slave_i), .start_i(start_i),
        .frames_done_i(frames_done_i), .data_i(data_i), .addr_o(addr_o),
        .prom_ce_n_o(prom_ce_n_o), .done_o(done_o), .slave_o(slave_o),
        .byte_stb_o(byte_stb_o), .ser_bit_o(ser_bit_o), .ser_vld_o(ser_vld_o),
        .dout_o(dout_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // called just after the edge that took byte b; ends on its bit 0
    task automatic chk_byte(input logic [7:0] b, input string req);
        check({req, " R4 strobe"}, byte_stb_o, 1'b1);
        check({req, " R5 bit7"}, ser_bit_o, b[7]);
        for (int j = 6; j >= 0; j--) begin
            tick();
            check({req, " R5 bit"}, ser_bit_o, b[j]);
            check({req, " R11 dout"}, dout_o, b[j]);
            check({req, " R4 no strobe"}, byte_stb_o, 1'b0);
        end
    endtask

    task automatic do_reset(input logic slave);
        rst_n = 1'b0;
        mode_slave_i = slave;
        start_i = 1'b0;
        frames_done_i = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        check("R1 addr", addr_o, '0);
        check("R1 done", done_o, 1'b0);
        check("R1 ce_n", prom_ce_n_o, 1'b0);
        check("R1 vld", ser_vld_o, 1'b0);
        check("R1 stb", byte_stb_o, 1'b0);
        check("R1 dout", dout_o, 1'b1);
    endtask

    task automatic t_master();
        use_prom = 1'b1;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check("R2 start addr", addr_o, START);
        tick();
        check("R3 not on first edge", byte_stb_o, 1'b0);
        check("R3 vld low", ser_vld_o, 1'b0);
        tick();
        chk_byte(prom(START), "R3 byte0");
        check("R6 addr+1", addr_o, START + 1);
        tick();
        // R8: toggle mode while loading
        mode_slave_i = 1'b1;
        chk_byte(prom(START + 1), "R4 byte1");
        check("R6 addr+2", addr_o, START + 2);
        tick();
        check("R8 slave_o", slave_o, 1'b0);
        check("R8 addr still steps", addr_o, START + 3);
        check("R4 byte2 strobe", byte_stb_o, 1'b1);
    endtask

    task automatic t_done();
        logic [7:0] b2;
        b2 = prom(START + 2);
        check("R5 byte2 bit7", ser_bit_o, b2[7]);
        tick(); tick();
        check("R5 byte2 bit5", ser_bit_o, b2[5]);
        frames_done_i = 1'b1;
        tick();
        frames_done_i = 1'b0;
        check("R9 done", done_o, 1'b1);
        check("R9 ce_n", prom_ce_n_o, 1'b1);
        check("R10 bit4", ser_bit_o, b2[4]);
        tick(); tick(); tick();
        check("R10 vld before end", ser_vld_o, 1'b1);
        check("R10 last bit", dout_o, b2[1]);
        tick();
        check("R10 bit0", ser_bit_o, b2[0]);
        tick();
        check("R10 vld falls", ser_vld_o, 1'b0);
        check("R11 dout idle", dout_o, 1'b1);
        for (int k = 0; k < 12; k++) begin
            tick();
            check("R9 no strobe", byte_stb_o, 1'b0);
            check("R9 addr frozen", addr_o, START + 3);
        end
        check("R9 done sticky", done_o, 1'b1);
    endtask

    task automatic t_slave();
        use_prom = 1'b0;
        do_reset(1'b1);
        check("R7 slave_o", slave_o, 1'b1);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check("R7 addr 0", addr_o, '0);
        data_drv = 8'hA5;
        tick();
        check("R3 slave first edge", byte_stb_o, 1'b0);
        tick();
        data_drv = 8'h3C;
        chk_byte(8'hA5, "R7 byte0");
        tick();
        chk_byte(8'h3C, "R7 byte1");
        check("R7 addr held", addr_o, '0);
    endtask

    initial begin
        #(200000 * 20);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_master();
        t_done();
        t_slave();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule